// File: doc/BRIEF.md
# Static Memory Bus Bridge

This block connects an internal 32-bit request port to an external static memory bus that is always 16 bits wide, such as an SRAM or a NOR flash. Two memory banks are served, each with its own active-low chip-select. The top address bit of a request picks the bank. Each bank keeps three timing settings:

- a read wait-state count,
- a write wait-state count,
- an output-enable delay.

A byte or half-word request runs as one external cycle. A word request runs as two half-word cycles, with the lower half first, and the requester sees no completion until both halves are done. The requester raises `req_valid` and holds its request fields steady. It waits for the one-cycle `req_ready` pulse, which comes with any read data, and then drops `req_valid`. The timing settings of a bank are written through a small configuration port. They are sampled when a request is accepted, so they hold for the whole of that request.

Top module: `smc_bridge`

## Requirements
- R1: While reset is active and directly after it, both chip-selects, output-enable and write-enable are high (inactive), `req_ready` is 0, and byte enables are 2'b11. After reset, every bank holds read wait 4, write wait 3 and output-enable delay 1.
- R2: Address bit AW-1 selects the bank: 0 drives `mem_cs_n` = 2'b10 and 1 drives 2'b01. At no time are both chip-selects low.
- R3: An external cycle holds its chip-select low for L = max(W, 2) consecutive clocks, where W is the 5-bit wait-state value in use. A value of 0 or 1 therefore still gives 2 clocks, and 31 gives 31.
- R4: Read cycles take W from the bank's read wait field. Write cycles take W from the bank's write wait field.
- R5: On a read, output-enable goes low D clocks after chip-select goes low and rises together with chip-select. D is the 4-bit delay clamped to L-1, so output-enable is low for at least one clock.
- R6: On a write, write-enable is low for all L clocks of the cycle and output-enable stays high. `mem_dout` carries the half-word being written.
- R7: A word request first accesses half-word address A and then A+1, where A is the word-aligned byte address divided by 2. Chip-select is high for exactly one clock between the two halves. Write data bits 15:0 go out first and bits 31:16 second. Read data is returned as {second half, first half}.
- R8: Byte and half-word requests take one external cycle at half-word address = byte address / 2. Byte enables are 2'b10 for a byte at an even address, 2'b01 for a byte at an odd address, and 2'b00 otherwise. A byte write drives the byte on both lanes. A byte read returns the addressed lane in bits 7:0. A half-word read returns the half in bits 15:0. Unused upper bits read 0.
- R9: `req_ready` is a one-clock pulse in the clock after the last external clock of the request, and it is low while the request is in progress. Request size 2'b00 is a byte, 2'b01 is a half-word, and 2'b1x is a word.
- R10: A configuration write (`cfg_wdata` = {delay[13:10], write wait[9:5], read wait[4:0]} to bank `cfg_bank`) made during a request does not change that request's timing. It applies from the next accepted request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 1 | Bank whose settings are written |
| cfg_wdata | input | 14 | {OE delay, write wait, read wait} |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 half-word, 1x word |
| req_addr | input | AW | Byte address, top bit selects bank |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Completion pulse |
| req_rdata | output | 32 | Read data, valid with req_ready |
| mem_cs_n | output | 2 | Per-bank chip-select, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low |
| mem_addr | output | AW-2 | Half-word address |
| mem_dout | output | 16 | Data driven to memory |
| mem_din | input | 16 | Data read from memory |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of an access. The old timing must be kept until the access completes and the new timing must apply to the very next one. To bring it about, the bench drives the configuration strobe on the first clock of a running read. It then checks the remaining clocks of that read against the old length and the following read against the new length. The clamp of the output-enable delay is reached by programming a delay of 15 against a short wait count. The two-clock floor is reached with wait values 0 and 1.

// File: rtl/smc_bridge.sv
module smc_bridge #(
  parameter int AW  = 12,
  parameter int WSW = 5,
  parameter int OEW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_bank,
  input  logic [OEW+2*WSW-1:0]   cfg_wdata,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [AW-1:0]          req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   req_ready,
  output logic [31:0]            req_rdata,
  output logic [1:0]             mem_cs_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [1:0]             mem_be_n,
  output logic [AW-3:0]          mem_addr,
  output logic [15:0]            mem_dout,
  input  logic [15:0]            mem_din
);

  localparam int HAW = AW - 2;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP, S_DONE} st_t;

  st_t            st;
  logic [WSW-1:0] cfg_rd [2];
  logic [WSW-1:0] cfg_wr [2];
  logic [OEW-1:0] cfg_oe [2];

  logic           bank_q, wr_q, word_q, byte_q, odd_q, second_q;
  logic [HAW-1:0] haddr_q;
  logic [31:0]    wdata_q, rdata_q;
  logic [15:0]    lo_q;
  logic [WSW-1:0] len_q, oed_q, cnt;

  logic           nb;
  logic [WSW-1:0] ws_sel, len_n, oe_ext, oed_n;
  logic           act, last;

  assign nb     = req_addr[AW-1];
  assign ws_sel = req_write ? cfg_wr[nb] : cfg_rd[nb];
  assign len_n  = (ws_sel < WSW'(2)) ? WSW'(2) : ws_sel;
  assign oe_ext = WSW'(cfg_oe[nb]);
  assign oed_n  = (oe_ext >= len_n) ? len_n - WSW'(1) : oe_ext;

  assign act  = (st == S_ACC);
  assign last = act && (cnt == len_q - WSW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        cfg_rd[i] <= WSW'(4);
        cfg_wr[i] <= WSW'(3);
        cfg_oe[i] <= OEW'(1);
      end
    end else if (cfg_we) begin
      cfg_rd[cfg_bank] <= cfg_wdata[WSW-1:0];
      cfg_wr[cfg_bank] <= cfg_wdata[2*WSW-1:WSW];
      cfg_oe[cfg_bank] <= cfg_wdata[2*WSW+OEW-1:2*WSW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bank_q   <= 1'b0;
      wr_q     <= 1'b0;
      word_q   <= 1'b0;
      byte_q   <= 1'b0;
      odd_q    <= 1'b0;
      second_q <= 1'b0;
      haddr_q  <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      lo_q     <= '0;
      len_q    <= WSW'(2);
      oed_q    <= '0;
      cnt      <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st       <= S_ACC;
          bank_q   <= nb;
          wr_q     <= req_write;
          word_q   <= req_size[1];
          byte_q   <= (req_size == 2'b00);
          odd_q    <= req_addr[0];
          second_q <= 1'b0;
          haddr_q  <= req_size[1] ? {req_addr[AW-2:2], 1'b0} : req_addr[AW-2:1];
          wdata_q  <= req_wdata;
          len_q    <= len_n;
          oed_q    <= oed_n;
          cnt      <= '0;
        end
        S_ACC: begin
          cnt <= cnt + WSW'(1);
          if (last) begin
            if (word_q && !second_q) begin
              lo_q     <= mem_din;
              second_q <= 1'b1;
              haddr_q  <= haddr_q + HAW'(1);
              st       <= S_GAP;
            end else begin
              if (word_q)      rdata_q <= {mem_din, lo_q};
              else if (byte_q) rdata_q <= {24'h0, odd_q ? mem_din[15:8] : mem_din[7:0]};
              else             rdata_q <= {16'h0, mem_din};
              st <= S_DONE;
            end
          end
        end
        S_GAP: begin
          cnt <= '0;
          st  <= S_ACC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_cs_n  = act ? ~(2'b01 << bank_q) : 2'b11;
  assign mem_oe_n  = !(act && !wr_q && (cnt >= oed_q));
  assign mem_we_n  = !(act && wr_q);
  assign mem_be_n  = !act ? 2'b11 : byte_q ? (odd_q ? 2'b01 : 2'b10) : 2'b00;
  assign mem_addr  = haddr_q;
  assign mem_dout  = byte_q ? {2{wdata_q[7:0]}} : (second_q ? wdata_q[31:16] : wdata_q[15:0]);
  assign req_ready = (st == S_DONE);
  assign req_rdata = rdata_q;

  // R2
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R5
  oe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !(&mem_cs_n));

  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R3
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mem_cs_n) && !(&$past(mem_cs_n))) |-> !(&$past(mem_cs_n, 2)));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R9
  ready_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_cs_n && mem_we_n));

endmodule

// File: tb/smc_bridge_tb.sv
module smc_bridge_tb;
  localparam int AW = 12;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, cfg_we, cfg_bank, req_valid, req_write, req_ready;
  logic [13:0] cfg_wdata;
  logic [1:0]  req_size, mem_cs_n, mem_be_n;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata, req_rdata;
  logic mem_oe_n, mem_we_n;
  logic [AW-3:0] mem_addr;
  logic [15:0] mem_dout, mem_din;

  smc_bridge #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din));

  logic [15:0] memarr [0:2047];
  logic        csb;
  assign csb = !mem_cs_n[1];
  assign mem_din = (!mem_oe_n && mem_cs_n != 2'b11) ? memarr[{csb, mem_addr}] : 16'h0;

  always @(posedge clk)
    if (!mem_we_n && mem_cs_n != 2'b11) begin
      if (!mem_be_n[0]) memarr[{csb, mem_addr}][7:0]  <= mem_dout[7:0];
      if (!mem_be_n[1]) memarr[{csb, mem_addr}][15:8] <= mem_dout[15:8];
    end

  int total = 0, bad = 0;
  bit finished = 0;
  int brd[2], bwr[2], boe[2];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setcfg(int b, int rd, int wr, int oe);
    cfg_we = 1; cfg_bank = b[0]; cfg_wdata = {oe[3:0], wr[4:0], rd[4:0]};
    @(negedge clk);
    cfg_we = 0;
    brd[b] = rd; bwr[b] = wr; boe[b] = oe;
  endtask

  task automatic do_req(int b, bit w, int size, int off, logic [31:0] wd,
                        logic [31:0] exp_rd, string tag, bit mid);
    int ws, len, d, nh, ha0;
    logic [1:0] be;
    ws  = w ? bwr[b] : brd[b];
    len = ws < 2 ? 2 : ws;
    d   = boe[b] >= len ? len - 1 : boe[b];
    nh  = size >= 2 ? 2 : 1;
    ha0 = size >= 2 ? (off >> 2) * 2 : off >> 1;
    be  = size == 0 ? (off[0] ? 2'b01 : 2'b10) : 2'b00;
    req_valid = 1; req_write = w; req_size = size[1:0];
    req_addr = {b[0], off[AW-2:0]}; req_wdata = wd;
    for (int h = 0; h < nh; h++) begin
      if (h == 1) begin
        @(negedge clk);
        chk({tag, " gap R7"}, {req_ready, mem_cs_n}, {1'b0, 2'b11});
      end
      for (int c = 0; c < len; c++) begin
        logic [15:0] ed;
        @(negedge clk);
        if (mid && h == 0 && c == 0) begin
          cfg_we = 1; cfg_bank = b[0]; cfg_wdata = {4'd0, 5'd9, 5'd9};
        end else cfg_we = 0;
        chk({tag, " cycle"},
            {req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_addr},
            {1'b0, ~(2'b01 << b), (w ? 1'b1 : (c >= d ? 1'b0 : 1'b1)), !w, be, 10'(ha0 + h)});
        ed = size == 0 ? {2{wd[7:0]}} : (h == 1 ? wd[31:16] : wd[15:0]);
        if (w) chk({tag, " wdata R6"}, mem_dout, ed);
      end
    end
    cfg_we = 0;
    @(negedge clk);
    chk({tag, " ready R9"}, {req_ready, mem_cs_n}, {1'b1, 2'b11});
    if (!w) chk({tag, " rdata"}, req_rdata, exp_rd);
    req_valid = 0;
    @(negedge clk);
    chk({tag, " one pulse R9"}, req_ready, 1'b0);
    if (mid) begin brd[b] = 9; bwr[b] = 9; boe[b] = 0; end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] old;
    for (int i = 0; i < 2048; i++) memarr[i] = 16'(i * 16'h0107) ^ 16'h5a3c;
    for (int b = 0; b < 2; b++) begin brd[b] = 4; bwr[b] = 3; boe[b] = 1; end
    rst_n = 0; cfg_we = 0; cfg_bank = 0; cfg_wdata = 0;
    req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}, {1'b0, 2'b11, 1'b1, 1'b1, 2'b11});
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}, {1'b0, 2'b11, 1'b1, 1'b1, 2'b11});

    do_req(0, 0, 1, 12'h024, 0, {16'h0, memarr[12'h012]}, "R1 default rd R4", 0);
    do_req(1, 0, 1, 12'h010, 0, {16'h0, memarr[12'h408]}, "R2 bank1", 0);

    setcfg(1, 0, 1, 0);
    do_req(1, 0, 1, 12'h030, 0, {16'h0, memarr[12'h418]}, "R3 min rd", 0);
    do_req(1, 1, 1, 12'h032, 32'h0000_beef, 0, "R3 min wr R6", 0);
    do_req(1, 0, 1, 12'h032, 0, 32'h0000_beef, "R6 readback", 0);

    setcfg(0, 6, 4, 15);
    do_req(0, 0, 1, 12'h040, 0, {16'h0, memarr[12'h020]}, "R5 clamp", 0);
    setcfg(0, 31, 4, 7);
    do_req(0, 0, 1, 12'h042, 0, {16'h0, memarr[12'h021]}, "R3 max R5", 0);

    setcfg(0, 5, 3, 2);
    do_req(0, 0, 2, 12'h086, 0, {memarr[12'h043], memarr[12'h042]}, "R7 word rd", 0);
    setcfg(1, 3, 8, 1);
    do_req(1, 1, 3, 12'h100, 32'hcafe_1234, 0, "R7 word wr R4", 0);
    do_req(1, 0, 2, 12'h100, 0, 32'hcafe_1234, "R7 word readback R4", 0);

    old = memarr[12'h010];
    do_req(0, 1, 0, 12'h021, 32'h0000_00a5, 0, "R8 byte wr odd", 0);
    do_req(0, 0, 1, 12'h020, 0, {16'h0, 8'ha5, old[7:0]}, "R8 merged half", 0);
    old = memarr[12'h011];
    do_req(0, 1, 0, 12'h022, 32'h0000_003c, 0, "R8 byte wr even", 0);
    do_req(0, 0, 0, 12'h022, 0, 32'h3c, "R8 byte rd even", 0);
    do_req(0, 0, 0, 12'h023, 0, {24'h0, old[15:8]}, "R8 byte rd odd", 0);

    do_req(0, 0, 1, 12'h050, 0, {16'h0, memarr[12'h028]}, "R10 mid cfg", 1);
    do_req(0, 0, 1, 12'h052, 0, {16'h0, memarr[12'h029]}, "R10 new cfg", 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule